// File: doc/BRIEF.md
# Converter Connect-and-Check Switch Sequencer

This block brings two redundant converters onto a high-voltage supply bus through mechanically latching switches. Before full voltage is applied, it tests each connection for a fault. The supply sends its intent through the polarity of a low bus voltage. With a positive bus, the block drives every switch open and returns to a known pre-start state. With a negative bus, it steps through a fixed connect-and-check routine, one action per tick of a slow step clock:

1. Close switch A.
2. Judge A and isolate it if a fault current is seen.
3. Close switch B, whatever the result for A.
4. Judge B and isolate it if a fault current is seen.
5. Mark the routine complete.

The logic runs from a supply that comes in bursts. While a supply-low flag is raised, every action is held off, and the step position and the flags keep their values. The routine therefore resumes at the same step on the next burst. The completion flag and the two health flags are retained, so they can be read later.

The fast system clock only registers the outputs. The step tick is a one-cycle enable whose period the system sets well above the switch actuation time and the charging transient. The fault flag is looked at only on the check ticks, after the charging transient has passed.

Top module: `sw_seq_top`

## Requirements
- R1: A step tick taken while the supply is good and `polNeg` is 0 gives a one-cycle pulse on `aOpen`, `bOpen` and `bypOpen` together. The same tick clears `seqDone`, sets `healthA` and `healthB` to 1, and returns the routine to its first step.
- R2: While `polNeg` is 1 and `seqDone` is 0, each accepted tick performs exactly one step, in this order: close A, check A, close B, check B, complete. A switch pulse appears in the clock cycle after the tick edge.
- R3: On the check-A tick, `faultDet`=1 gives an `aOpen` pulse and sets `healthA` to 0. `faultDet`=0 gives no pulse and sets `healthA` to 1. `faultDet` has no effect on any other step.
- R4: On the check-B tick, `faultDet`=1 gives a `bOpen` pulse and sets `healthB` to 0, while `faultDet`=0 leaves B closed with `healthB`=1. B is closed on the step before, even when A was found faulty.
- R5: On the completion tick, `seqDone` goes to 1. While `seqDone` is 1 and `polNeg` is 1, ticks produce no pulse and leave all three flags unchanged.
- R6: While `supplyLow` is 1, ticks are ignored: no pulse is produced, and the step position and flags are kept. The next tick with the supply good performs the step that was pending.
- R7: A positive-polarity tick after completion allows the whole negative routine to run again from close A.
- R8: Every switch command is one clock wide, and no command appears in a cycle that follows a cycle without a step tick.
- R9: After reset, all pulse outputs are 0, `seqDone` is 0, and `healthA` and `healthB` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on) |
| stepTick | input | 1 | One-cycle enable marking a slow step |
| polNeg | input | 1 | Bus polarity: 1 negative, 0 positive |
| faultDet | input | 1 | Fault current seen on the connection under test |
| supplyLow | input | 1 | Logic supply below threshold; holds all actions |
| aClose | output | 1 | Close pulse for switch A |
| aOpen | output | 1 | Open pulse for switch A |
| bClose | output | 1 | Close pulse for switch B |
| bOpen | output | 1 | Open pulse for switch B |
| bypOpen | output | 1 | Open pulse for the bypass switch |
| seqDone | output | 1 | Negative routine has finished |
| healthA | output | 1 | Converter A state: 1 OK, 0 faulted |
| healthB | output | 1 | Converter B state: 1 OK, 0 faulted |

## Verification
The routine is run in directed form with four fault patterns:

- no faults;
- A only;
- B only;
- a fault flag held high through the close steps.

These separate a check that samples on the right tick from one that latches the charging spike, and they show that the B connection does not depend on the A result. One run drops the supply in the middle of the routine, which tells a design that resumes at its step apart from one that restarts or skips. Random runs mix polarity flips, supply drops and fault values against a step model in the bench. They catch any ordering where completion, restart or the supply hold interact wrongly.

// File: rtl/swseq_pkg.sv
package swseq_pkg;
  // Strobes from the step control to the switch/flag datapath.
  typedef struct packed {
    logic clrAll;   // positive-polarity reset of switches and flags
    logic closeA;
    logic checkA;
    logic closeB;
    logic checkB;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/swseq_ctrl.sv
module swseq_ctrl
  import swseq_pkg::*;
#(
  parameter int STEPS = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    stepTick,
  input  logic    supplyLow,
  input  logic    polNeg,
  input  logic    seqDone,
  output strobe_t stb
);
  localparam int POS_W = $clog2(STEPS);
  localparam logic [POS_W-1:0] P_CLOSE_A = POS_W'(0);
  localparam logic [POS_W-1:0] P_CHECK_A = POS_W'(1);
  localparam logic [POS_W-1:0] P_CLOSE_B = POS_W'(2);
  localparam logic [POS_W-1:0] P_CHECK_B = POS_W'(3);
  localparam logic [POS_W-1:0] P_LAST    = POS_W'(STEPS - 1);

  logic [POS_W-1:0] pos;
  logic live;
  logic act;

  assign live = stepTick & ~supplyLow;
  assign act  = live & polNeg & ~seqDone;

  // Retained step position: held while the supply is low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      pos <= '0;
    else if (live && !polNeg)       pos <= '0;
    else if (act && pos != P_LAST)  pos <= pos + 1'b1;
  end

  always_comb begin
    stb        = '0;
    stb.clrAll = live & ~polNeg;
    stb.closeA = act & (pos == P_CLOSE_A);
    stb.checkA = act & (pos == P_CHECK_A);
    stb.closeB = act & (pos == P_CLOSE_B);
    stb.checkB = act & (pos == P_CHECK_B);
    stb.finish = act & (pos == P_LAST);
  end
endmodule

// File: rtl/swseq_dp.sv
module swseq_dp
  import swseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    faultDet,
  output logic    aClose,
  output logic    aOpen,
  output logic    bClose,
  output logic    bOpen,
  output logic    bypOpen,
  output logic    seqDone,
  output logic    healthA,
  output logic    healthB
);
  // Switch command pulses: one clock wide, the switches latch on their own.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aClose  <= 1'b0;
      aOpen   <= 1'b0;
      bClose  <= 1'b0;
      bOpen   <= 1'b0;
      bypOpen <= 1'b0;
    end else begin
      aClose  <= stb.closeA;
      bClose  <= stb.closeB;
      aOpen   <= stb.clrAll | (stb.checkA & faultDet);
      bOpen   <= stb.clrAll | (stb.checkB & faultDet);
      bypOpen <= stb.clrAll;
    end
  end

  // Retained flags; only the strobes touch them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqDone <= 1'b0;
      healthA <= 1'b1;
      healthB <= 1'b1;
    end else if (stb.clrAll) begin
      seqDone <= 1'b0;
      healthA <= 1'b1;
      healthB <= 1'b1;
    end else begin
      if (stb.checkA) healthA <= ~faultDet;
      if (stb.checkB) healthB <= ~faultDet;
      if (stb.finish) seqDone <= 1'b1;
    end
  end
endmodule

// File: rtl/sw_seq_top.sv
module sw_seq_top
  import swseq_pkg::*;
#(
  parameter int STEPS = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic stepTick,
  input  logic polNeg,
  input  logic faultDet,
  input  logic supplyLow,
  output logic aClose,
  output logic aOpen,
  output logic bClose,
  output logic bOpen,
  output logic bypOpen,
  output logic seqDone,
  output logic healthA,
  output logic healthB
);
  strobe_t stb;

  swseq_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .supplyLow(supplyLow),
    .polNeg(polNeg), .seqDone(seqDone), .stb(stb)
  );

  swseq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .faultDet(faultDet),
    .aClose(aClose), .aOpen(aOpen), .bClose(bClose), .bOpen(bOpen),
    .bypOpen(bypOpen), .seqDone(seqDone), .healthA(healthA), .healthB(healthB)
  );
endmodule

// File: rtl/sw_seq_chk.sv
module sw_seq_chk (
  input logic clk,
  input logic rstN,
  input logic stepTick,
  input logic polNeg,
  input logic supplyLow,
  input logic aClose,
  input logic aOpen,
  input logic bClose,
  input logic bOpen,
  input logic bypOpen,
  input logic seqDone,
  input logic healthA,
  input logic healthB
);
  logic anyPulse;
  assign anyPulse = aClose | aOpen | bClose | bOpen | bypOpen;

  AST_POS_OPENS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (stepTick && !supplyLow && !polNeg) |=> (aOpen && bOpen && bypOpen && !seqDone && healthA && healthB)); // R1

  AST_NO_CLOSE_OPEN_A: assert property (@(posedge clk) disable iff (!rstN)
    (aClose |-> !aOpen) and (bClose |-> !bOpen)); // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && polNeg) |=> (!anyPulse && $stable(healthA) && $stable(healthB) && seqDone)); // R5

  AST_LOW_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> (!anyPulse && $stable(seqDone) && $stable(healthA) && $stable(healthB))); // R6

  AST_NO_TICK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stepTick |=> !anyPulse); // R8

  AST_CLOSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (aClose || bClose) |=> (!aClose && !bClose)); // R8
endmodule

bind sw_seq_top sw_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .stepTick(stepTick), .polNeg(polNeg),
  .supplyLow(supplyLow), .aClose(aClose), .aOpen(aOpen), .bClose(bClose),
  .bOpen(bOpen), .bypOpen(bypOpen), .seqDone(seqDone), .healthA(healthA),
  .healthB(healthB)
);

// File: tb/sim_sw_seq_top.sv
`timescale 1ns/1ps
module sim_sw_seq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepTick = 1'b0;
  logic polNeg = 1'b0;
  logic faultDet = 1'b0;
  logic supplyLow = 1'b0;
  logic aClose, aOpen, bClose, bOpen, bypOpen, seqDone, healthA, healthB;

  int total = 0;
  int bad = 0;

  // Bench step model
  int   mPos  = 0;
  logic mDone = 1'b0;
  logic mHA   = 1'b1;
  logic mHB   = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  sw_seq_top u0 (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .polNeg(polNeg),
    .faultDet(faultDet), .supplyLow(supplyLow), .aClose(aClose), .aOpen(aOpen),
    .bClose(bClose), .bOpen(bOpen), .bypOpen(bypOpen), .seqDone(seqDone),
    .healthA(healthA), .healthB(healthB)
  );

  function automatic logic [7:0] outVec();
    return {aClose, aOpen, bClose, bOpen, bypOpen, seqDone, healthA, healthB};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b {aC,aO,bC,bO,byp,done,hA,hB}", tag, got, exp);
    end
  endtask

  // One step tick with the given inputs, checked against the model.
  task automatic doTick(input logic pNeg, input logic flt, input logic low, input string tagIn);
    logic [4:0] ep;
    string tag;
    ep = '0;
    if (tagIn != "") tag = tagIn;
    else if (low) tag = "R6";
    else if (!pNeg) tag = "R1";
    else if (mDone) tag = "R5";
    else if (mPos == 1) tag = "R3";
    else if (mPos == 3) tag = "R4";
    else tag = "R2";
    if (!low) begin
      if (!pNeg) begin
        ep = 5'b01011; mPos = 0; mDone = 1'b0; mHA = 1'b1; mHB = 1'b1;
      end else if (!mDone) begin
        case (mPos)
          0: ep[4] = 1'b1;
          1: begin ep[3] = flt; mHA = ~flt; end
          2: ep[2] = 1'b1;
          3: begin ep[1] = flt; mHB = ~flt; end
          default: mDone = 1'b1;
        endcase
        if (mPos < 4) mPos++;
      end
    end
    @(negedge clk);
    polNeg = pNeg; faultDet = flt; supplyLow = low; stepTick = 1'b1;
    @(negedge clk);
    stepTick = 1'b0;
    check(tag, outVec(), {ep, mDone, mHA, mHB});
    @(negedge clk);
    check("R8", outVec(), {5'b00000, mDone, mHA, mHB});
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL R2 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R9", outVec(), 8'b00000011);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", outVec(), 8'b00000011);

    // No faults: full routine
    doTick(1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 5; i++) doTick(1'b1, 1'b0, 1'b0, "R2");
    doTick(1'b1, 1'b1, 1'b0, "R5");
    doTick(1'b1, 1'b0, 1'b0, "R5");

    // Restart, fault on A only; B still closed
    doTick(1'b0, 1'b0, 1'b0, "R7");
    doTick(1'b1, 1'b0, 1'b0, "R7");
    doTick(1'b1, 1'b1, 1'b0, "R3");
    doTick(1'b1, 1'b0, 1'b0, "R4");
    doTick(1'b1, 1'b0, 1'b0, "R4");
    doTick(1'b1, 1'b0, 1'b0, "R5");

    // Fault on B only; fault held on close steps is ignored
    doTick(1'b0, 1'b0, 1'b0, "R1");
    doTick(1'b1, 1'b1, 1'b0, "R3");
    doTick(1'b1, 1'b0, 1'b0, "R3");
    doTick(1'b1, 1'b1, 1'b0, "R4");
    doTick(1'b1, 1'b1, 1'b0, "R4");
    doTick(1'b1, 1'b1, 1'b0, "R5");

    // Supply drop mid-routine, then resume
    doTick(1'b0, 1'b0, 1'b0, "R1");
    doTick(1'b1, 1'b0, 1'b0, "R2");
    doTick(1'b1, 1'b1, 1'b1, "R6");
    doTick(1'b0, 1'b0, 1'b1, "R6");
    doTick(1'b1, 1'b1, 1'b0, "R6");
    doTick(1'b1, 1'b0, 1'b1, "R6");
    doTick(1'b1, 1'b0, 1'b0, "R6");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic rp, rf, rl;
      rp = ($urandom % 8) != 0;
      rf = $urandom % 2;
      rl = ($urandom % 6) == 0;
      doTick(rp, rf, rl, "");
      if (($urandom % 4) == 0) repeat ($urandom % 5) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule